// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block splits a loop of arbitrary element count into pieces that a vector unit of fixed capacity can consume. Software or a control engine presents a total element count and a base byte address with a one-cycle start pulse. The block then presents a series of chunks on a valid/ready handshake. Each chunk carries the index of its first element, the number of elements in it and the byte address of that first element. Elements are 8 bytes wide, so addresses step by eight bytes per element.

The short remainder chunk, holding the count modulo the vector capacity, is presented first. Every chunk after it is exactly full. When the count divides evenly, no empty chunk ever appears, and the first chunk is already full. A one-cycle done pulse follows the last accepted chunk. A zero count produces the done pulse alone. The capacity is a parameter. A power-of-two capacity uses bit slicing for the quotient and remainder; any other capacity uses a constant divider.

Top module: `vlen_strip_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, chunk_valid_o and done_o are low.
- R2: When the count is not a multiple of MAX_VL, the first chunk has index 0 and length count mod MAX_VL.
- R3: Every chunk after the first has length exactly MAX_VL.
- R4: After each accepted chunk (valid and ready high at a clock edge), the next chunk's index is the previous index plus the previous length. The lengths of one sequence add up to the count.
- R5: A chunk's address equals base + index × 8, with both values captured at start.
- R6: When the count is a nonzero multiple of MAX_VL, the first chunk presented has index 0 and length MAX_VL. A chunk of length 0 is never presented.
- R7: A start with a count of 0 raises done_o in the cycle after the start edge, and no chunk is presented.
- R8: While chunk_valid_o is high and chunk_ready_i is low, the index, length and address hold their values and valid stays high.
- R9: A start pulse that arrives while a sequence is running, or in its done cycle, is ignored and does not change the chunks.
- R10: A sequence presents floor(count / MAX_VL) chunks, plus one if the remainder is nonzero. done_o is high for exactly one cycle, right after the edge that accepts the last chunk, and valid is low in that cycle.
- R11: For a nonzero count, chunk_valid_o rises in the cycle right after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| total_i | input | CNT_W | Total element count, sampled on start |
| base_i | input | ADDR_W | Byte address of element 0, sampled on start |
| chunk_valid_o | output | 1 | A chunk is presented |
| chunk_ready_i | input | 1 | Downstream accepts the presented chunk |
| chunk_idx_o | output | CNT_W | Index of the chunk's first element |
| chunk_len_o | output | $clog2(MAX_VL+1) | Element count of the chunk |
| chunk_addr_o | output | ADDR_W | Byte address of the chunk's first element |
| done_o | output | 1 | One-cycle pulse after the last chunk |

## Verification
The bench targets these cases: exact multiples of the capacity, a count of zero, a count of one, a count one below the capacity, and counts with both a remainder and several full chunks. A design that forgot to skip the empty remainder would present a length-0 chunk. One that put the remainder last would show the short length at the wrong index. Stall patterns on ready catch a design that advances its index or address without a handshake. A start pulse in the middle of a run catches a design that restarts and repeats index 0. Chunk counts and length sums are checked per sequence, so an off-by-one in the iteration count shows up as a missing or extra chunk, or a wrongly timed done.

// File: rtl/vss_pkg.sv
package vss_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_ISSUE  = 2'd1,
      SEQ_FINISH = 2'd2
   } seq_state_e;

   localparam int unsigned ELEM_BYTES = 8;
   localparam int unsigned ELEM_SHIFT = 3;

endpackage

// File: rtl/vss_divmod.sv
module vss_divmod #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned MAX_VL = 64,
   parameter int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
   input  logic [CNT_W-1:0] num_i,
   output logic [CNT_W-1:0] quot_o,
   output logic [LEN_W-1:0] rem_o
);

   localparam bit          IS_POW2 = (MAX_VL & (MAX_VL - 1)) == 0;
   localparam int unsigned SH      = $clog2(MAX_VL);

   initial begin
      assert (MAX_VL >= 2) else $error("vss_divmod: MAX_VL must be at least 2");
      assert (LEN_W >= $clog2(MAX_VL + 1)) else $error("vss_divmod: LEN_W too narrow");
   end

   generate
      if (IS_POW2) begin : g_pow2
         // Quotient and remainder fall out of the bit pattern.
         always_comb begin
            quot_o = num_i >> SH;
            rem_o  = '0;
            rem_o[SH-1:0] = num_i[SH-1:0];
         end
      end else begin : g_const_div
         logic [CNT_W-1:0] full_rem;
         always_comb begin
            quot_o   = num_i / CNT_W'(MAX_VL);
            full_rem = num_i % CNT_W'(MAX_VL);
            rem_o    = full_rem[LEN_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/vss_seq_ctrl.sv
module vss_seq_ctrl
   import vss_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned MAX_VL = 64,
   parameter int unsigned LEN_W  = $clog2(MAX_VL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] total_i,
   input  logic [CNT_W-1:0] quot_i,
   input  logic [LEN_W-1:0] rem_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic [CNT_W-1:0] idx_o,
   output logic [LEN_W-1:0] len_o,
   output logic             done_o,
   output logic             load_o,
   output logic             step_o
);

   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_VL);

   seq_state_e       state_q;
   logic [CNT_W-1:0] idx_q;
   logic [LEN_W-1:0] len_q;
   logic [CNT_W-1:0] left_q;
   logic             has_rem;

   assign has_rem = (rem_i != '0);
   assign valid_o = (state_q == SEQ_ISSUE);
   assign done_o  = (state_q == SEQ_FINISH);
   assign load_o  = (state_q == SEQ_IDLE) && start_i;
   assign step_o  = valid_o && ready_i;
   assign idx_o   = idx_q;
   assign len_o   = len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         len_q   <= '0;
         left_q  <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start_i) begin
                  idx_q <= '0;
                  if (total_i == '0) begin
                     state_q <= SEQ_FINISH;
                  end else begin
                     state_q <= SEQ_ISSUE;
                     len_q   <= has_rem ? rem_i : LEN_MAX;
                     left_q  <= quot_i + CNT_W'(has_rem);
                  end
               end
            end
            SEQ_ISSUE: begin
               if (ready_i) begin
                  idx_q  <= idx_q + CNT_W'(len_q);
                  len_q  <= LEN_MAX;
                  left_q <= left_q - 1'b1;
                  if (left_q == CNT_W'(1)) state_q <= SEQ_FINISH;
               end
            end
            SEQ_FINISH: state_q <= SEQ_IDLE;
            default:    state_q <= SEQ_IDLE;
         endcase
      end
   end

   p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (len_o != '0) && (len_o <= LEN_MAX));

   p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(idx_o) && $stable(len_o));

   p_idx_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ready_i |=> !valid_o || (idx_o == $past(idx_o) + CNT_W'($past(len_o))));

   p_full_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ready_i |=> !valid_o || (len_o == LEN_MAX));

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o);

   p_empty_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_IDLE) && start_i && (total_i == '0) |=> done_o && !valid_o);

   p_first_chunk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_IDLE) && start_i && (total_i != '0) |=> valid_o && (idx_o == '0));

   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i && start_i |=> valid_o && $stable(idx_o));

endmodule

// File: rtl/vss_addr_gen.sv
module vss_addr_gen #(
   parameter int unsigned ADDR_W     = 48,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned LEN_W      = 7,
   parameter int unsigned ELEM_SHIFT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              step_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              valid_i,
   input  logic [CNT_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] base_q;

   initial begin
      assert (ADDR_W > ELEM_SHIFT) else $error("vss_addr_gen: ADDR_W too narrow");
   end

   // Running sum: one adder instead of an index-by-size multiplier.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         base_q <= '0;
      end else if (load_i) begin
         addr_q <= base_i;
         base_q <= base_i;
      end else if (step_i) begin
         addr_q <= addr_q + (ADDR_W'(len_i) << ELEM_SHIFT);
      end
   end

   assign addr_o = addr_q;

   p_addr_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |-> addr_q == base_q + (ADDR_W'(idx_i) << ELEM_SHIFT));

   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && !step_i |=> $stable(addr_q));

endmodule

// File: rtl/vlen_strip_seq.sv
module vlen_strip_seq
   import vss_pkg::*;
#(
   parameter int unsigned MAX_VL = 64,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 48
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [CNT_W-1:0]             total_i,
   input  logic [ADDR_W-1:0]            base_i,
   output logic                         chunk_valid_o,
   input  logic                         chunk_ready_i,
   output logic [CNT_W-1:0]             chunk_idx_o,
   output logic [$clog2(MAX_VL+1)-1:0]  chunk_len_o,
   output logic [ADDR_W-1:0]            chunk_addr_o,
   output logic                         done_o
);

   localparam int unsigned LEN_W = $clog2(MAX_VL + 1);

   initial begin
      assert (MAX_VL >= 2) else $error("vlen_strip_seq: MAX_VL must be at least 2");
      assert (CNT_W > LEN_W) else $error("vlen_strip_seq: CNT_W must exceed LEN_W");
      assert (ELEM_BYTES == (1 << ELEM_SHIFT)) else $error("vlen_strip_seq: element size mismatch");
   end

   logic [CNT_W-1:0] quot;
   logic [LEN_W-1:0] rem;
   logic             load;
   logic             step;

   vss_divmod #(
      .CNT_W (CNT_W),
      .MAX_VL(MAX_VL),
      .LEN_W (LEN_W)
   ) u_divmod (
      .num_i (total_i),
      .quot_o(quot),
      .rem_o (rem)
   );

   vss_seq_ctrl #(
      .CNT_W (CNT_W),
      .MAX_VL(MAX_VL),
      .LEN_W (LEN_W)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .total_i(total_i),
      .quot_i (quot),
      .rem_i  (rem),
      .ready_i(chunk_ready_i),
      .valid_o(chunk_valid_o),
      .idx_o  (chunk_idx_o),
      .len_o  (chunk_len_o),
      .done_o (done_o),
      .load_o (load),
      .step_o (step)
   );

   vss_addr_gen #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .LEN_W     (LEN_W),
      .ELEM_SHIFT(ELEM_SHIFT)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .base_i (base_i),
      .step_i (step),
      .len_i  (chunk_len_o),
      .valid_i(chunk_valid_o),
      .idx_i  (chunk_idx_o),
      .addr_o (chunk_addr_o)
   );

endmodule

// File: tb/vlen_strip_seq_tb.sv
`timescale 1ns/1ps
module vlen_strip_seq_tb;

   localparam int MVL = 64;
   localparam int CW  = 32;
   localparam int AW  = 48;
   localparam int LW  = $clog2(MVL + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] total = '0;
   logic [AW-1:0] base = '0;
   logic          ready = 1'b0;
   logic          valid;
   logic [CW-1:0] idx;
   logic [LW-1:0] len;
   logic [AW-1:0] addr;
   logic          done;

   int checks = 0;
   int failures = 0;
   int ready_mode = 0;
   int cyc = 0;
   int hs_cnt = 0;
   longint len_sum = 0;

   // reference model state
   int          q_len[$];
   bit          m_busy = 0;
   bit          m_done = 0;
   longint      m_idx = 0;
   logic [AW-1:0] m_base = '0;

   always #2.5 clk = ~clk;   // 200 MHz

   vlen_strip_seq #(.MAX_VL(MVL), .CNT_W(CW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .total_i(total), .base_i(base),
      .chunk_valid_o(valid), .chunk_ready_i(ready), .chunk_idx_o(idx),
      .chunk_len_o(len), .chunk_addr_o(addr), .done_o(done)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
      end
   endtask

   // ready pattern driver
   initial begin
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         case (ready_mode)
            0: ready = 1'b1;
            1: ready = (cyc % 3) == 0;
            default: ready = (cyc % 4) != 1;
         endcase
      end
   end

   // behavioural reference model, advanced on each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         q_len.delete(); m_busy = 0; m_done = 0; m_idx = 0;
      end else if (m_done) begin
         m_done = 0; m_busy = 0;
      end else if (q_len.size() > 0) begin
         if (ready) begin
            m_idx = m_idx + q_len[0];
            void'(q_len.pop_front());
            if (q_len.size() == 0) m_done = 1;
         end
      end else if (!m_busy && start) begin
         m_busy = 1; m_idx = 0; m_base = base;
         if ((total % MVL) != 0) q_len.push_back(int'(total % MVL));
         for (int i = 0; i < int'(total / MVL); i++) q_len.push_back(MVL);
         if (q_len.size() == 0) m_done = 1;
      end
   end

   // compare on every cycle, away from the edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [AW-1:0] exp_addr;
         bit exp_valid;
         exp_valid = q_len.size() > 0;
         chk(valid == exp_valid, "R11/R10 valid", valid, exp_valid);
         chk(done == m_done, "R7/R10 done", done, m_done);
         if (valid && exp_valid) begin
            exp_addr = m_base + AW'(m_idx * 8);
            chk(len == LW'(q_len[0]), (m_idx == 0) ? "R2/R6 first len" : "R3 full len",
                len, q_len[0]);
            chk(idx == CW'(m_idx), "R4/R9 index", idx, m_idx);
            chk(addr == exp_addr, "R5/R8 address", addr, exp_addr);
         end
         if (valid && ready) begin
            hs_cnt++;
            len_sum += len;
         end
      end
   end

   task automatic run_seq(input int n, input logic [AW-1:0] b, input int mode, input bit intrude);
      int exp_cnt;
      exp_cnt = n / MVL + ((n % MVL) != 0 ? 1 : 0);
      @(posedge clk); #1;
      ready_mode = mode; total = CW'(n); base = b; start = 1'b1;
      hs_cnt = 0; len_sum = 0;
      @(posedge clk); #1;
      start = 1'b0;
      if (intrude) begin
         // R9: start pulse during a running sequence must be ignored
         repeat (3) @(posedge clk);
         #1; start = 1'b1; total = 7; base = 48'h55;
         @(posedge clk); #1; start = 1'b0;
      end
      @(negedge clk);
      while (m_busy) @(negedge clk);
      chk(hs_cnt == exp_cnt, "R10 chunk count", hs_cnt, exp_cnt);
      chk(len_sum == n, "R4 length sum", len_sum, n);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(valid == 1'b0, "R1 reset valid", valid, 0);
      chk(done == 1'b0, "R1 reset done", done, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk(valid == 1'b0 && done == 1'b0, "R1 after reset", {valid, done}, 0);

      run_seq(130, 48'h0000_1000_0000, 0, 0);  // R2 remainder then R3 full
      run_seq(64,  48'h0000_0000_2000, 0, 0);  // R6 exact multiple
      run_seq(0,   48'h0000_0000_3000, 0, 0);  // R7 empty
      run_seq(5,   48'h0000_0000_0008, 0, 0);
      run_seq(200, 48'h0123_4567_8000, 1, 0);  // R8 heavy stalls
      run_seq(1,   48'h0000_0000_0040, 2, 0);
      run_seq(63,  48'h0000_0000_0100, 2, 0);
      run_seq(128, 48'h0000_0000_4000, 1, 0);  // R6 with stalls
      run_seq(191, 48'h0000_0000_8000, 1, 1);  // R9 intrusion while stalled
      run_seq(300, 48'h0000_0001_0000, 0, 1);  // R9 intrusion while streaming

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule